// File: doc/BRIEF.md
# Stack Pointer Limit Guard

This block owns a core's stack pointer and a per-task limit register. It checks every stack pointer update the core proposes against the limit. An update can be a push, a pop or a direct load. If a push or a load would carry the pointer past the limit, the block refuses it, keeps the old pointer value and raises an overflow pulse for exception logic. It also latches the refused value and sets a sticky flag, so the handler can later see what went wrong.

The limit can be rewritten at any time through a small register-write port, so context-switch code can install each task's bound. A limit of zero means "no bound". This allows a safe switch sequence: clear the limit, load the incoming task's pointer, then install its limit. A mode input selects whether the stack grows toward lower addresses (the default) or toward higher ones. Both the pointer and the limit are kept word aligned.

Top module: `sp_limit_guard`

## Requirements
- R1: With `grow_up` low, a push or load whose resulting address is strictly below a nonzero limit faults. A push that wraps below address zero also faults.
- R2: A faulting update leaves `sp` at its previous value. `ovf_pulse` is high for exactly the one cycle after the clock edge that sampled the faulting update.
- R3: A resulting address exactly equal to the limit is legal in both growth directions.
- R4: While `limit` is zero, no update faults in either direction. A push that wraps past either end of the address space is then accepted, with the wrapped value.
- R5: With `grow_up` high, a push or load whose result is strictly above a nonzero limit faults. A push that carries past the top of the address space also faults.
- R6: On a fault, the refused address (low 32 bits) is latched into `fault_addr` and `fault_flag` is set. Writing select 2'b10 with data bit 0 set clears the flag. A fault in the same cycle as that clear leaves the flag set.
- R7: Bits [1:0] are forced to zero in register writes to `sp` and `limit`, in load values, and in push/pop amounts.
- R8: The encoding of `upd_op` is: 2'b00 push (move toward growth by `upd_val`), 2'b01 pop (move away by `upd_val`, never checked), 2'b10 load `upd_val`, 2'b11 no-op (no change, no fault).
- R9: Reset clears `sp`, `limit`, `fault_addr`, `fault_flag` and `ovf_pulse`.
- R10: Register selects are 2'b00 `sp` and 2'b01 `limit`. A register write to `sp` overrides a core update in the same cycle, and that update then cannot fault. A core update in the same cycle as a limit write is checked against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grow_up | input | 1 | 1: stack grows toward higher addresses |
| upd_valid | input | 1 | Core proposes a stack pointer update |
| upd_op | input | 2 | Update kind: push, pop, load, no-op |
| upd_val | input | DW | Push/pop amount in bytes, or load value |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: sp, limit, status |
| cfg_wdata | input | DW | Register write data |
| sp | output | DW | Current stack pointer |
| limit | output | DW | Current limit |
| fault_addr | output | DW | Last refused address |
| fault_flag | output | 1 | Sticky overflow flag |
| ovf_pulse | output | 1 | One-cycle overflow exception pulse |

## Verification
The hardest conditions to reach are the address-space wraparounds. A push that borrows below zero, or carries past the top, has low bits that look like a perfectly legal address. The stimulus reaches these cases by placing the pointer a few words from either end through a register write, then pushing more than the remaining distance. This is done both with a nonzero limit (the push must fault) and with a zero limit (the wrapped value must be accepted). Same-cycle collisions are driven by one task that asserts a register write and a core update in a single cycle:
- a pointer write against a load;
- a limit write against a push;
- a status clear against a new fault.

// File: rtl/sp_limit_guard.sv
module sp_limit_guard #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grow_up,
  input  logic          upd_valid,
  input  logic [1:0]    upd_op,
  input  logic [DW-1:0] upd_val,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] limit,
  output logic [DW-1:0] fault_addr,
  output logic          fault_flag,
  output logic          ovf_pulse
);

  localparam logic [DW-1:0] WMASK = {{(DW-2){1'b1}}, 2'b00};
  localparam logic [1:0] OP_PUSH = 2'b00, OP_POP = 2'b01, OP_LOAD = 2'b10, OP_NOP = 2'b11;
  localparam logic [1:0] SEL_SP = 2'b00, SEL_LIM = 2'b01, SEL_STAT = 2'b10;

  logic [DW-1:0] amt;
  logic [DW:0]   inc, dec, toward, away, prop;
  logic          sp_wr, active, checked, over, fault;

  assign amt    = upd_val & WMASK;
  assign inc    = {1'b0, sp} + {1'b0, amt};
  assign dec    = {1'b0, sp} - {1'b0, amt};
  assign toward = grow_up ? inc : dec;
  assign away   = grow_up ? dec : inc;

  always_comb begin
    case (upd_op)
      OP_PUSH: prop = toward;
      OP_POP:  prop = {1'b0, away[DW-1:0]};
      OP_LOAD: prop = {1'b0, upd_val & WMASK};
      default: prop = {1'b0, sp};
    endcase
  end

  assign sp_wr   = cfg_we && (cfg_sel == SEL_SP);
  assign active  = upd_valid && !sp_wr && (upd_op != OP_NOP);
  assign checked = (upd_op == OP_PUSH) || (upd_op == OP_LOAD);
  assign over    = prop[DW] || (grow_up ? (prop[DW-1:0] > limit) : (prop[DW-1:0] < limit));
  assign fault   = active && checked && (limit != '0) && over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp         <= '0;
      limit      <= '0;
      fault_addr <= '0;
      fault_flag <= 1'b0;
      ovf_pulse  <= 1'b0;
    end else begin
      ovf_pulse <= fault;
      if (sp_wr)
        sp <= cfg_wdata & WMASK;
      else if (active && !fault)
        sp <= prop[DW-1:0];
      if (cfg_we && cfg_sel == SEL_LIM)
        limit <= cfg_wdata & WMASK;
      if (fault) begin
        fault_addr <= prop[DW-1:0];
        fault_flag <= 1'b1;
      end else if (cfg_we && cfg_sel == SEL_STAT && cfg_wdata[0]) begin
        fault_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sp_limit_guard_chk.sv
module sp_limit_guard_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_valid,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [DW-1:0] sp,
  input logic [DW-1:0] limit,
  input logic          fault_flag,
  input logic          ovf_pulse
);

  AST_HOLD_SP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> sp == $past(sp)); // R2

  AST_FLAG_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> fault_flag); // R6

  AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && limit == '0) |=> !ovf_pulse); // R4

  AST_SP_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'b00) |=> !ovf_pulse); // R10

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (sp[1:0] == 2'b00) && (limit[1:0] == 2'b00)); // R7

  AST_QUIET_WITHOUT_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> !ovf_pulse); // R2

endmodule

bind sp_limit_guard sp_limit_guard_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .sp(sp), .limit(limit), .fault_flag(fault_flag),
  .ovf_pulse(ovf_pulse)
);

// File: tb/sp_limit_guard_test.sv
module sp_limit_guard_test;
  localparam int DW = 32;
  logic clk = 0, rst_n = 0, grow_up = 0;
  logic upd_valid = 0, cfg_we = 0;
  logic [1:0] upd_op = 0, cfg_sel = 0;
  logic [DW-1:0] upd_val = 0, cfg_wdata = 0;
  logic [DW-1:0] sp, limit, fault_addr;
  logic fault_flag, ovf_pulse;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sp_limit_guard #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .grow_up(grow_up), .upd_valid(upd_valid),
    .upd_op(upd_op), .upd_val(upd_val), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sp(sp), .limit(limit), .fault_addr(fault_addr),
    .fault_flag(fault_flag), .ovf_pulse(ovf_pulse));

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [1:0] sel, logic [DW-1:0] wd,
                      logic uv, logic [1:0] op, logic [DW-1:0] val);
    @(negedge clk);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    upd_valid = uv; upd_op = op; upd_val = val;
    @(posedge clk); #1;
    cfg_we = 0; upd_valid = 0;
  endtask

  task automatic wr(logic [1:0] sel, logic [DW-1:0] d); step(1, sel, d, 0, 0, 0); endtask
  task automatic up(logic [1:0] op, logic [DW-1:0] v); step(0, 0, 0, 1, op, v); endtask
  task automatic idle(); step(0, 0, 0, 0, 0, 0); endtask

  task automatic t_reset();
    chk("R9 sp", sp, 0); chk("R9 limit", limit, 0); chk("R9 addr", fault_addr, 0);
    chk("R9 flag", {31'b0, fault_flag}, 0); chk("R9 pulse", {31'b0, ovf_pulse}, 0);
  endtask

  task automatic t_down();
    grow_up = 0;
    wr(2'b00, 32'h1000); wr(2'b01, 32'h0F00);
    up(2'b00, 32'h100);
    chk("R3 equal legal sp", sp, 32'h0F00); chk("R3 no pulse", {31'b0, ovf_pulse}, 0);
    up(2'b00, 32'h4);
    chk("R2 sp held", sp, 32'h0F00); chk("R2 pulse", {31'b0, ovf_pulse}, 1);
    chk("R1 addr", fault_addr, 32'h0EFC); chk("R6 flag set", {31'b0, fault_flag}, 1);
    idle();
    chk("R2 pulse one cycle", {31'b0, ovf_pulse}, 0);
    up(2'b01, 32'h10);
    chk("R8 pop", sp, 32'h0F10); chk("R6 sticky", {31'b0, fault_flag}, 1);
    wr(2'b10, 32'h1);
    chk("R6 cleared", {31'b0, fault_flag}, 0);
    up(2'b10, 32'h0E00);
    chk("R1 load below", {31'b0, ovf_pulse}, 1); chk("R1 load addr", fault_addr, 32'h0E00);
    chk("R1 load sp held", sp, 32'h0F10);
    up(2'b11, 32'h40);
    chk("R8 nop sp", sp, 32'h0F10); chk("R8 nop pulse", {31'b0, ovf_pulse}, 0);
  endtask

  task automatic t_wrap_down();
    grow_up = 0;
    wr(2'b01, 32'h100); wr(2'b00, 32'h4);
    up(2'b00, 32'h8);
    chk("R1 borrow fault", {31'b0, ovf_pulse}, 1); chk("R1 borrow addr", fault_addr, 32'hFFFF_FFFC);
    chk("R1 borrow sp", sp, 32'h4);
  endtask

  task automatic t_zero();
    grow_up = 0;
    wr(2'b01, 32'h0);
    up(2'b10, 32'h4);
    chk("R4 load low", sp, 32'h4); chk("R4 no pulse", {31'b0, ovf_pulse}, 0);
    up(2'b00, 32'h8);
    chk("R4 wrap accepted", sp, 32'hFFFF_FFFC); chk("R4 wrap no pulse", {31'b0, ovf_pulse}, 0);
    up(2'b10, 32'h9000); wr(2'b01, 32'h8000);
    up(2'b00, 32'h1000);
    chk("R4 switch seq sp", sp, 32'h8000); chk("R4 switch seq pulse", {31'b0, ovf_pulse}, 0);
  endtask

  task automatic t_up();
    grow_up = 1;
    wr(2'b01, 32'h2000); wr(2'b00, 32'h1F00);
    up(2'b00, 32'h100);
    chk("R3 up equal", sp, 32'h2000); chk("R3 up no pulse", {31'b0, ovf_pulse}, 0);
    up(2'b00, 32'h4);
    chk("R5 up fault", {31'b0, ovf_pulse}, 1); chk("R5 up addr", fault_addr, 32'h2004);
    chk("R5 up sp held", sp, 32'h2000);
    up(2'b01, 32'h40);
    chk("R8 up pop", sp, 32'h1FC0);
    up(2'b10, 32'h3000);
    chk("R5 up load fault", fault_addr, 32'h3000); chk("R5 load sp", sp, 32'h1FC0);
    wr(2'b01, 32'hFFFF_FFF0); wr(2'b00, 32'hFFFF_FFE0);
    up(2'b00, 32'h40);
    chk("R5 carry fault", {31'b0, ovf_pulse}, 1); chk("R5 carry addr", fault_addr, 32'h20);
    wr(2'b01, 32'h0);
    up(2'b00, 32'h40);
    chk("R4 up zero wrap", sp, 32'h20); chk("R4 up zero pulse", {31'b0, ovf_pulse}, 0);
    grow_up = 0;
  endtask

  task automatic t_align();
    grow_up = 0;
    wr(2'b01, 32'h3);
    chk("R7 limit mask", limit, 32'h0);
    wr(2'b00, 32'h1237);
    chk("R7 sp mask", sp, 32'h1234);
    up(2'b10, 32'h5557);
    chk("R7 load mask", sp, 32'h5554);
    up(2'b00, 32'h7);
    chk("R7 amount mask", sp, 32'h5550);
  endtask

  task automatic t_prio();
    grow_up = 0;
    wr(2'b01, 32'h1000); wr(2'b00, 32'h2000);
    step(1, 2'b00, 32'h3000, 1, 2'b10, 32'h10);
    chk("R10 sp write wins", sp, 32'h3000); chk("R10 no pulse", {31'b0, ovf_pulse}, 0);
    step(1, 2'b01, 32'h2800, 1, 2'b00, 32'h800);
    chk("R10 old limit sp", sp, 32'h2800); chk("R10 new limit", limit, 32'h2800);
    chk("R10 old limit pulse", {31'b0, ovf_pulse}, 0);
    wr(2'b10, 32'h1);
    step(1, 2'b10, 32'h1, 1, 2'b00, 32'h4);
    chk("R6 set beats clear", {31'b0, fault_flag}, 1); chk("R6 addr", fault_addr, 32'h27FC);
  endtask

  initial begin
    #23 rst_n = 1;
    t_reset();
    t_down();
    t_wrap_down();
    t_zero();
    t_up();
    t_align();
    t_prio();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule